// File: doc/BRIEF.md
# DMA Request Selector for a Card Data FIFO

This block decides which handshake request a card-interface data path shows to a system DMA controller. It has four request lines: single, burst, last-single and last-burst. The transfer direction sets how it chooses. When receiving, it looks at the FIFO word occupancy and at a flag that reports that the data counter has run out. When transmitting, it looks at how many words are still to be written into the FIFO. The burst size is a parameter and is eight words by default.

The selector is a small state machine. Its states are `ST_IDLE`, `ST_HOLD_SINGLE`, `ST_HOLD_BURST`, `ST_HOLD_LSINGLE` and `ST_HOLD_LBURST`. It has four kinds of transition:
- **arm**: from `ST_IDLE` to a hold state, when the data path is enabled and the decoders find a matching condition.
- **release**: from any hold state back to `ST_IDLE`, when the clear strobe from the DMA controller is seen.
- **abort**: from any state to `ST_IDLE`, when the data-path enable is low.
- **stay**: a hold state keeps its request, whatever the occupancy or counts do.

The request outputs are flip-flops loaded from the next-state value. A request therefore rises on the same edge that enters its hold state.

Top module: `dmarq_request_gen`

## Requirements
- R1: Receive (`dir_tx`=0). Single is raised when `cnt_zero`=1 and 1 < `fifo_level` < 8. Last-single is raised when `cnt_zero`=1 and `fifo_level`=1.
- R2: Receive. Burst is raised when `fifo_level` > 8, or when `fifo_level`=8 and `cnt_zero`=0. Last-burst is raised when `fifo_level`=8 and `cnt_zero`=1.
- R3: Transmit (`dir_tx`=1), using `tx_remain`. A value above 8 gives burst, exactly 8 gives last-burst, 2 to 7 gives single, and exactly 1 gives last-single. `fifo_level` and `cnt_zero` are ignored.
- R4: When no condition matches, no request is raised. Examples are a receive occupancy of 0, a receive occupancy below 8 with `cnt_zero`=0, and `tx_remain`=0.
- R5: At most one of the four request outputs is high in any cycle.
- R6: Once raised, a request stays high until `dma_clr` is sampled high. Changes to direction, occupancy, counter flag or remaining count have no effect while it is held.
- R7: A request sampled with `dma_clr` high is low after that edge. The conditions are evaluated again at the following edge, so a request can rise again one cycle after the clear.
- R8: With `en` low at an edge, all requests are low after that edge, and none rises while `en` stays low.
- R9: While `rst_n` is low, all four requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Data-path enable |
| dir_tx | input | 1 | Direction: 1 = transmit, 0 = receive |
| fifo_level | input | OCC_W (5) | FIFO word occupancy |
| cnt_zero | input | 1 | Data counter has reached zero |
| tx_remain | input | CNT_W (16) | Words still to be moved into the FIFO (transmit) |
| dma_clr | input | 1 | Request clear strobe from the DMA controller |
| req_single | output | 1 | Single-word request |
| req_burst | output | 1 | Burst request |
| req_last_single | output | 1 | Last single-word request |
| req_last_burst | output | 1 | Last burst request |

## Verification
Every result appears one clock edge after the stimulus that causes it:
- An arm shows up after the first edge at which the inputs match in `ST_IDLE`.
- A release or an abort shows up after the edge at which `dma_clr` or a low `en` is sampled.
- A re-armed request shows up one edge after that.

The bench drives inputs on the falling edge and compares outputs at the next falling edge, so each comparison sees exactly one rising edge. The sweep covers every occupancy and remaining count from 0 to 16 in both directions. It holds the counter flag at both values, and the hold, clear, re-arm and disable checks each take their own single-edge step.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_SINGLE  = 3'd1,
        KIND_BURST   = 3'd2,
        KIND_LSINGLE = 3'd3,
        KIND_LBURST  = 3'd4
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_HOLD_SINGLE  = 3'd1,
        ST_HOLD_BURST   = 3'd2,
        ST_HOLD_LSINGLE = 3'd3,
        ST_HOLD_LBURST  = 3'd4
    } sel_state_e;

    typedef struct packed {
        logic single;
        logic burst;
        logic lsingle;
        logic lburst;
    } req_vec_t;

endpackage

// File: rtl/dmarq_rx_decode.sv
module dmarq_rx_decode
    import dmarq_pkg::*;
#(
    parameter int OCC_W = 5,
    parameter int BURST = 8
) (
    input  logic [OCC_W-1:0] fifo_level,
    input  logic             cnt_zero,
    output req_kind_e        kind
);
    localparam logic [OCC_W-1:0] LVL_BURST = OCC_W'(BURST);
    localparam logic [OCC_W-1:0] LVL_ONE   = OCC_W'(1);

    always_comb begin
        kind = KIND_NONE;
        if (fifo_level > LVL_BURST) begin
            kind = KIND_BURST;
        end else if (fifo_level == LVL_BURST) begin
            kind = cnt_zero ? KIND_LBURST : KIND_BURST;
        end else if (cnt_zero && fifo_level == LVL_ONE) begin
            kind = KIND_LSINGLE;
        end else if (cnt_zero && fifo_level > LVL_ONE) begin
            kind = KIND_SINGLE;
        end
    end
endmodule

// File: rtl/dmarq_tx_decode.sv
module dmarq_tx_decode
    import dmarq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BURST = 8
) (
    input  logic [CNT_W-1:0] tx_remain,
    output req_kind_e        kind
);
    localparam logic [CNT_W-1:0] REM_BURST = CNT_W'(BURST);
    localparam logic [CNT_W-1:0] REM_ONE   = CNT_W'(1);

    always_comb begin
        kind = KIND_NONE;
        if (tx_remain > REM_BURST) begin
            kind = KIND_BURST;
        end else if (tx_remain == REM_BURST) begin
            kind = KIND_LBURST;
        end else if (tx_remain > REM_ONE) begin
            kind = KIND_SINGLE;
        end else if (tx_remain == REM_ONE) begin
            kind = KIND_LSINGLE;
        end
    end
endmodule

// File: rtl/dmarq_fsm.sv
module dmarq_fsm
    import dmarq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      dma_clr,
    input  req_kind_e kind,
    output req_vec_t  req
);
    sel_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;                       // abort
        end else begin
            unique case (state_q)
                ST_IDLE: begin                       // arm
                    unique case (kind)
                        KIND_SINGLE:  state_d = ST_HOLD_SINGLE;
                        KIND_BURST:   state_d = ST_HOLD_BURST;
                        KIND_LSINGLE: state_d = ST_HOLD_LSINGLE;
                        KIND_LBURST:  state_d = ST_HOLD_LBURST;
                        default:      state_d = ST_IDLE;
                    endcase
                end
                ST_HOLD_SINGLE,
                ST_HOLD_BURST,
                ST_HOLD_LSINGLE,
                ST_HOLD_LBURST: begin                // release or stay
                    if (dma_clr) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs, loaded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req <= '0;
        end else begin
            req.single  <= (state_d == ST_HOLD_SINGLE);
            req.burst   <= (state_d == ST_HOLD_BURST);
            req.lsingle <= (state_d == ST_HOLD_LSINGLE);
            req.lburst  <= (state_d == ST_HOLD_LBURST);
        end
    end
endmodule

// File: rtl/dmarq_request_gen.sv
module dmarq_request_gen
    import dmarq_pkg::*;
#(
    parameter int OCC_W = 5,
    parameter int CNT_W = 16,
    parameter int BURST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_tx,
    input  logic [OCC_W-1:0] fifo_level,
    input  logic             cnt_zero,
    input  logic [CNT_W-1:0] tx_remain,
    input  logic             dma_clr,
    output logic             req_single,
    output logic             req_burst,
    output logic             req_last_single,
    output logic             req_last_burst
);
    req_kind_e kind_rx, kind_tx, kind_sel;
    req_vec_t  req;

    dmarq_rx_decode #(.OCC_W(OCC_W), .BURST(BURST)) u_rx (
        .fifo_level (fifo_level),
        .cnt_zero   (cnt_zero),
        .kind       (kind_rx)
    );

    dmarq_tx_decode #(.CNT_W(CNT_W), .BURST(BURST)) u_tx (
        .tx_remain  (tx_remain),
        .kind       (kind_tx)
    );

    assign kind_sel = dir_tx ? kind_tx : kind_rx;

    dmarq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .dma_clr (dma_clr),
        .kind    (kind_sel),
        .req     (req)
    );

    assign req_single      = req.single;
    assign req_burst       = req.burst;
    assign req_last_single = req.lsingle;
    assign req_last_burst  = req.lburst;
endmodule

// File: rtl/dmarq_checker.sv
module dmarq_checker #(
    parameter int OCC_W = 5,
    parameter int CNT_W = 16,
    parameter int BURST = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             dir_tx,
    input logic [OCC_W-1:0] fifo_level,
    input logic             cnt_zero,
    input logic [CNT_W-1:0] tx_remain,
    input logic             dma_clr,
    input logic             req_single,
    input logic             req_burst,
    input logic             req_last_single,
    input logic             req_last_burst
);
    logic [3:0] reqs;
    assign reqs = {req_single, req_burst, req_last_single, req_last_burst};

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|reqs && !dma_clr && en) |=> (reqs == $past(reqs)));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|reqs && dma_clr) |=> (reqs == 4'b0000));

    a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (reqs == 4'b0000));

    a_r3_tx_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_burst) && $past(dir_tx)) |-> ($past(tx_remain) > CNT_W'(BURST)));

    a_r1_rx_lsingle: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_last_single) && !$past(dir_tx)) |->
            ($past(cnt_zero) && $past(fifo_level) == OCC_W'(1)));
endmodule

bind dmarq_request_gen dmarq_checker #(.OCC_W(OCC_W), .CNT_W(CNT_W), .BURST(BURST)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (en),
    .dir_tx          (dir_tx),
    .fifo_level      (fifo_level),
    .cnt_zero        (cnt_zero),
    .tx_remain       (tx_remain),
    .dma_clr         (dma_clr),
    .req_single      (req_single),
    .req_burst       (req_burst),
    .req_last_single (req_last_single),
    .req_last_burst  (req_last_burst)
);

// File: tb/tb_dmarq_request_gen.sv
module tb_dmarq_request_gen;
    localparam int CLK_PERIOD = 10;
    localparam int OCC_W = 5;
    localparam int CNT_W = 16;
    localparam int BURST = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic dir_tx = 1'b0;
    logic [OCC_W-1:0] fifo_level = '0;
    logic cnt_zero = 1'b0;
    logic [CNT_W-1:0] tx_remain = '0;
    logic dma_clr = 1'b0;
    logic req_single, req_burst, req_last_single, req_last_burst;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmarq_request_gen #(.OCC_W(OCC_W), .CNT_W(CNT_W), .BURST(BURST)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_tx(dir_tx),
        .fifo_level(fifo_level), .cnt_zero(cnt_zero), .tx_remain(tx_remain),
        .dma_clr(dma_clr), .req_single(req_single), .req_burst(req_burst),
        .req_last_single(req_last_single), .req_last_burst(req_last_burst)
    );

    // bits: {single, burst, last_single, last_burst}
    function automatic logic [3:0] expect_req(input logic tx, input int v, input logic z);
        if (tx) begin
            if (v > BURST)       return 4'b0100;
            else if (v == BURST) return 4'b0001;
            else if (v >= 2)     return 4'b1000;
            else if (v == 1)     return 4'b0010;
            else                 return 4'b0000;
        end else begin
            if (v > BURST)             return 4'b0100;
            else if (v == BURST)       return z ? 4'b0001 : 4'b0100;
            else if (z && v == 1)      return 4'b0010;
            else if (z && v > 1)       return 4'b1000;
            else                       return 4'b0000;
        end
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {req_single, req_burst, req_last_single, req_last_burst};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (dir_tx=%0b lvl=%0d rem=%0d zero=%0b)",
                     tag, act, exp, dir_tx, fifo_level, tx_remain, cnt_zero);
        end
    endtask

    task automatic check_excl(input string tag);
        n_checks++;
        if ($countones({req_single, req_burst, req_last_single, req_last_burst}) > 1) begin
            n_fail++;
            $display("FAIL %s: actual %b expected at most one bit set", tag,
                     {req_single, req_burst, req_last_single, req_last_burst});
        end
    endtask

    task automatic apply(input logic tx, input int v, input logic z);
        dir_tx = tx;
        fifo_level = OCC_W'(v);
        tx_remain = CNT_W'(v);
        cnt_zero = z;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        apply(1'b1, 12, 1'b1);
        en = 1'b1;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R9 reset", 4'b0000);
        rst_n = 1'b1;
        en = 1'b0;
        @(negedge clk);
        check("R8 idle with en low", 4'b0000);

        for (int d = 0; d < 2; d++) begin
            for (int v = 0; v <= 16; v++) begin
                for (int zi = 0; zi < 2; zi++) begin
                    logic [3:0] e;
                    logic tx, z;
                    tx = logic'(d);
                    z = logic'(zi);
                    e = expect_req(tx, v, z);
                    apply(tx, v, z);
                    en = 1'b1;
                    @(negedge clk);
                    if (e == 4'b0000)      check("R4 no match", e);
                    else if (tx)           check("R3 tx select", e);
                    else if (e[3] || e[1]) check("R1 rx single", e);
                    else                   check("R2 rx burst", e);
                    check_excl("R5 exclusive");
                    if (e != 4'b0000) begin
                        // disturb all inputs; request must stay
                        apply(~tx, 16 - v, ~z);
                        @(negedge clk);
                        check("R6 hold", e);
                        dma_clr = 1'b1;
                        @(negedge clk);
                        check("R7 cleared", 4'b0000);
                        dma_clr = 1'b0;
                        apply(tx, v, z);
                        @(negedge clk);
                        check("R7 re-eval", e);
                    end
                    en = 1'b0;
                    @(negedge clk);
                    check("R8 enable drop", 4'b0000);
                end
            end
        end

        // R8: no request rises while en stays low
        apply(1'b1, 12, 1'b0);
        en = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 stays low", 4'b0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule